// File: doc/BRIEF.md
# Serial flash command packet decoder

This block sits between a host link that delivers packets one byte per cycle and a serial bus sequencer. It watches for a flash command start packet and reads the 16-bit count and the 32-bit flags word from its header. It checks the request against the device's size limits and against what the attached bus can do. From the packed flag fields it works out how many bytes the sequencer must shift out and how many it must read back.

On an accepted request the decoder passes the write payload on as a stream of indexed bytes. The payload comes from the start packet and from any continuation packets that follow. Once the number of bytes forwarded equals the outgoing total, the decoder sends the sequencer a one-cycle start request and stays busy until the sequencer reports that it is done. A request that fails a check is answered with a 16-bit status code and never reaches the sequencer.

Packets are framed by `rx_valid` and `rx_last`. Every multi-byte field is little-endian. A start packet is laid out as: id at offsets 0-1, count at 2-3, flags at 4-7, payload from offset 8.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy`, `start_req`, `status_valid` and `wr_valid` are all 0.
- R2: A packet is treated as a start packet only if its first two bytes, read little-endian, equal `START_ID` (9). A packet with any other id, including the same bytes in the opposite order, produces no status, no payload byte and no start request.
- R3: For a write (flags bit 31 = 1), `send_len` is the sum of four terms: the write-enable bit (flags bit 28), the opcode length (flags bits 1:0), the address length (flags bits 4:2) and the count. `recv_len` is 0, and `cmd_flags` carries the flags word.
- R4: For a read (flags bit 31 = 0), `send_len` is the write-enable bit plus the opcode length plus the address length, and `recv_len` equals the count.
- R5: Payload bytes are forwarded on `wr_valid`/`wr_data`, with `wr_index` starting at 0 and counting up. They come from start-packet offsets 8 through 63 and from continuation packets (id `CONT_ID` = 4, payload from offset 2). Bytes beyond `send_len` are dropped.
- R6: `start_req` is a one-cycle pulse. It rises in the same cycle as the forwarded byte whose index is `send_len-1`. If `send_len` is 0, it rises in the cycle after the last flags byte is taken.
- R7: A write count above `MAX_WR` (256), or a read count above `MAX_RD` (256), is answered with status `BAD_COUNT_CODE` (0x0004). No payload and no start request follow.
- R8: While `enable` is 0, a start packet is answered with status `DISABLED_CODE` (0x0007) and no start request.
- R9: While `multilane_ok` is 0, a nonzero lane-mode field (flags bits 6:5), the double-rate bit (flags bit 9) or a nonzero dummy-cycle field (flags bits 14:10) is answered with status 0x000A. While `multilane_ok` is 1, the same request is accepted.
- R10: `busy` rises together with `start_req` and falls in the cycle after `seq_done`. Start packets that arrive while `busy` is 1 are ignored.
- R11: When several checks fail, the disabled status takes precedence over the count status, and the count status takes precedence over the 0x000A status.
- R12: A continuation packet that arrives while no accepted request is collecting payload is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enabled |
| multilane_ok | input | 1 | Attached bus supports multi-lane, double-rate and dummy-cycle phases |
| rx_valid | input | 1 | A packet byte is present this cycle |
| rx_data | input | 8 | Packet byte |
| rx_last | input | 1 | This byte ends the packet |
| seq_done | input | 1 | Sequencer has finished the transaction |
| start_req | output | 1 | One-cycle start request to the sequencer |
| send_len | output | 17 | Bytes to shift out |
| recv_len | output | 16 | Bytes to read back |
| cmd_flags | output | 32 | Flags word of the accepted request |
| busy | output | 1 | Transaction outstanding |
| wr_valid | output | 1 | Payload byte valid |
| wr_data | output | 8 | Payload byte |
| wr_index | output | 17 | Position of the payload byte in the outgoing stream |
| status_valid | output | 1 | Error status valid (one cycle) |
| status_code | output | 16 | Error status code |

## Verification
The bench checks every output event in order, so internal faults show up at the ports quickly. A wrong byte position or a wrong index register appears at the first forwarded payload byte as a mismatched `wr_index` or `wr_data`. A bad length sum appears as a `start_req` that comes one byte early or late, or as a wrong `send_len` in that same cycle. A stale busy or collecting state shows within a few cycles of the next packet: it either drops an event the scoreboard expects or produces one it does not.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          MAX_WR            = 256,
  parameter int          MAX_RD            = 256,
  parameter int          START_ID          = 9,
  parameter int          CONT_ID           = 4,
  parameter int          START_PAYLOAD_MAX = 56,
  parameter logic [15:0] BAD_COUNT_CODE    = 16'h0004,
  parameter logic [15:0] DISABLED_CODE     = 16'h0007
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        multilane_ok,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        seq_done,
  output logic        start_req,
  output logic [16:0] send_len,
  output logic [15:0] recv_len,
  output logic [31:0] cmd_flags,
  output logic        busy,
  output logic        wr_valid,
  output logic [7:0]  wr_data,
  output logic [16:0] wr_index,
  output logic        status_valid,
  output logic [15:0] status_code
);
  localparam logic [15:0] UNSUP_CODE = 16'h000A;
  localparam int          PAY_END    = 8 + START_PAYLOAD_MAX;

  logic [6:0]  pos;
  logic [7:0]  id_lo;
  logic        is_start, is_cont, collecting;
  logic [15:0] cnt_q;
  logic [23:0] flag_q;
  logic [16:0] idx;

  wire [15:0] pkt_id     = {rx_data, id_lo};
  wire [31:0] flags_full = {rx_data, flag_q};
  wire        is_wr      = flags_full[31];
  wire [16:0] prefix     = 17'(flags_full[28]) + 17'(flags_full[1:0]) + 17'(flags_full[4:2]);
  wire [16:0] total_n    = is_wr ? prefix + 17'(cnt_q) : prefix;
  wire [15:0] recv_n     = is_wr ? 16'd0 : cnt_q;
  wire        too_many   = {1'b0, cnt_q} > (is_wr ? 17'(MAX_WR) : 17'(MAX_RD));
  wire        needs_ml   = (flags_full[6:5] != 2'b00) || (flags_full[14:9] != 6'd0);

  logic [15:0] err_code;
  always_comb begin
    if (!enable)                      err_code = DISABLED_CODE;
    else if (too_many)                err_code = BAD_COUNT_CODE;
    else if (needs_ml && !multilane_ok) err_code = UNSUP_CODE;
    else                              err_code = 16'h0000;
  end

  wire decide = rx_valid && is_start && (pos == 7'd7) && !busy;
  wire in_pay = (is_start && pos >= 7'd8 && 32'(pos) < PAY_END) || (is_cont && pos >= 7'd2);
  wire take   = rx_valid && collecting && in_pay && (idx < send_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; id_lo <= '0; is_start <= 1'b0; is_cont <= 1'b0;
      cnt_q <= '0; flag_q <= '0; idx <= '0; collecting <= 1'b0;
      start_req <= 1'b0; send_len <= '0; recv_len <= '0; cmd_flags <= '0;
      busy <= 1'b0; wr_valid <= 1'b0; wr_data <= '0; wr_index <= '0;
      status_valid <= 1'b0; status_code <= '0;
    end else begin
      start_req    <= 1'b0;
      status_valid <= 1'b0;
      wr_valid     <= 1'b0;
      if (seq_done) busy <= 1'b0;
      if (rx_valid) begin
        pos <= rx_last ? 7'd0 : (pos == 7'h7f ? pos : pos + 7'd1);
        case (pos)
          7'd0: id_lo <= rx_data;
          7'd1: begin
            is_start <= (pkt_id == 16'(START_ID)) && !busy;
            is_cont  <= (pkt_id == 16'(CONT_ID));
          end
          7'd2: if (is_start) cnt_q[7:0]    <= rx_data;
          7'd3: if (is_start) cnt_q[15:8]   <= rx_data;
          7'd4: if (is_start) flag_q[7:0]   <= rx_data;
          7'd5: if (is_start) flag_q[15:8]  <= rx_data;
          7'd6: if (is_start) flag_q[23:16] <= rx_data;
          default: ;
        endcase
      end
      if (decide) begin
        cmd_flags <= flags_full;
        idx       <= '0;
        if (err_code != 16'h0000) begin
          status_valid <= 1'b1;
          status_code  <= err_code;
          collecting   <= 1'b0;
        end else begin
          send_len <= total_n;
          recv_len <= recv_n;
          if (total_n == 17'd0) begin
            start_req  <= 1'b1;
            busy       <= 1'b1;
            collecting <= 1'b0;
          end else begin
            collecting <= 1'b1;
          end
        end
      end
      if (take) begin
        wr_valid <= 1'b1;
        wr_data  <= rx_data;
        wr_index <= idx;
        idx      <= idx + 17'd1;
        if (idx + 17'd1 == send_len) begin
          start_req  <= 1'b1;
          busy       <= 1'b1;
          collecting <= 1'b0;
        end
      end
    end
  end

  // R6: start request is a single-cycle pulse
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);
  // R10: busy only rises with a start request
  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start_req);
  // R10: a start request always leaves the block busy
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> busy);
  // R7: an error status never coincides with a start request
  assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> (!start_req && status_code != 16'h0000));
  // R5: forwarded bytes stay inside the outgoing total
  assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_index < send_len));
  // R3: a write never asks for read-back bytes
  assert_write_norecv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && cmd_flags[31]) |-> (recv_len == 16'd0));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, multilane_ok = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, seq_done = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic start_req, busy, wr_valid, status_valid;
  logic [16:0] send_len, wr_index;
  logic [15:0] recv_len, status_code;
  logic [31:0] cmd_flags;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .multilane_ok(multilane_ok),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .seq_done(seq_done),
    .start_req(start_req), .send_len(send_len), .recv_len(recv_len),
    .cmd_flags(cmd_flags), .busy(busy), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_index(wr_index), .status_valid(status_valid), .status_code(status_code));

  typedef struct {
    int kind;   // 0 payload byte, 1 start request, 2 status
    int a;
    int b;
    int c;
    int req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  bit m_busy = 0, m_coll = 0;
  int m_total = 0, m_idx = 0, pkt_no = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int a, input int b, input int c, input int req);
    item_t e;
    e.kind = kind; e.a = a; e.b = b; e.c = c; e.req = req;
    q.push_back(e);
  endtask

  task automatic compare(input int kind, input int a, input int b, input int c);
    item_t e;
    if (q.size() == 0) begin
      check(1'b0, "R2/R12", "unexpected event kind", kind, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == kind && e.a == a && e.b == b && e.c == c,
            $sformatf("R%0d", e.req), $sformatf("event kind %0d field a", kind), a, e.a);
    end
  endtask

  // Monitor: compares every output event with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid)     compare(0, int'(wr_index), int'(wr_data), 0);
      if (start_req)    compare(1, int'(send_len), int'(recv_len), int'(cmd_flags));
      if (status_valid) compare(2, int'(status_code), 0, 0);
    end
  end

  task automatic drive(input logic [7:0] b[$]);
    foreach (b[i]) begin
      rx_valid = 1'b1; rx_data = b[i]; rx_last = (i == b.size() - 1);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pay(input int i);
    return 8'((pkt_no * 37 + i * 5 + 3) & 8'hff);
  endfunction

  task automatic take_byte(input int i, input logic [7:0] d);
    if (m_coll && m_idx < m_total) begin
      push(0, m_idx, int'(d), 0, 5); // R5
      m_idx++;
      if (m_idx == m_total) begin
        push(1, m_total, -1, 0, 6); // R6: fields patched below
        m_busy = 1; m_coll = 0;
      end
    end
    if (i < 0) $display("unused");
  endtask

  // Start packet with a given id; bench-side model of the expected response
  task automatic start_pkt(input int id, input int cnt, input logic [31:0] fl, input int npay);
    logic [7:0] b[$];
    int err, pre, tot, rcv;
    bit wr;
    item_t e;
    pkt_no++;
    b.push_back(8'(id)); b.push_back(8'(id >> 8));
    b.push_back(8'(cnt)); b.push_back(8'(cnt >> 8));
    for (int k = 0; k < 4; k++) b.push_back(fl[8*k +: 8]);
    for (int k = 0; k < npay; k++) b.push_back(pay(k));
    wr  = fl[31];
    pre = int'(fl[28]) + int'(fl[1:0]) + int'(fl[4:2]);
    tot = wr ? pre + cnt : pre;
    rcv = wr ? 0 : cnt;
    if (!enable) err = 16'h0007;
    else if (cnt > 256) err = 16'h0004;
    else if (!multilane_ok && (fl[6:5] != 0 || fl[14:9] != 0)) err = 16'h000A;
    else err = 0;
    if (id == 9 && !m_busy) begin
      if (err != 0) begin
        push(2, err, 0, 0, 7); // R7/R8/R9/R11
        m_coll = 0;
      end else begin
        m_total = tot; m_idx = 0;
        if (tot == 0) begin
          push(1, 0, rcv, int'(fl), 6); // R6
          m_busy = 1;
        end else m_coll = 1;
        for (int k = 0; k < npay && k < 56; k++) begin
          take_byte(k, pay(k));
        end
        // fix start item fields for recv length and flags
        foreach (q[j]) if (q[j].kind == 1 && q[j].b == -1) begin
          e = q[j]; e.b = rcv; e.c = int'(fl); e.req = wr ? 3 : 4; q[j] = e;
        end
      end
    end
    drive(b);
  endtask

  int last_rcv = 0;
  logic [31:0] last_fl = 0;

  task automatic cont_pkt(input int npay, input int rcv, input logic [31:0] fl);
    logic [7:0] b[$];
    item_t e;
    pkt_no++;
    b.push_back(8'h04); b.push_back(8'h00);
    for (int k = 0; k < npay; k++) begin
      b.push_back(pay(k));
      take_byte(k, pay(k));
    end
    foreach (q[j]) if (q[j].kind == 1 && q[j].b == -1) begin
      e = q[j]; e.b = rcv; e.c = int'(fl); e.req = 5; q[j] = e;
    end
    drive(b);
  endtask

  task automatic drain(input string req);
    repeat (3) @(negedge clk);
    check(q.size() == 0, req, "expected events outstanding", q.size(), 0);
    q.delete();
  endtask

  task automatic finish_seq();
    seq_done = 1'b1; @(negedge clk); seq_done = 1'b0; m_busy = 0;
    @(negedge clk);
    check(busy == 1'b0, "R10", "busy after seq_done", int'(busy), 0);
  endtask

  localparam logic [31:0] WR = 32'h8000_0000;
  localparam logic [31:0] WE = 32'h1000_0000;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && start_req == 0 && status_valid == 0 && wr_valid == 0,
          "R1", "outputs under reset", int'({busy, start_req, status_valid, wr_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1", "busy after reset", int'(busy), 0);

    // R3: write, we + opcode 1 + address 3 + count 4 = 9
    start_pkt(9, 4, WR | WE | 32'h0000_000D, 9);
    drain("R3");
    check(busy == 1, "R10", "busy after start", int'(busy), 1);
    finish_seq();

    // R4: read, opcode 1 + address 3, 16 read back
    start_pkt(9, 16, 32'h0000_000D, 4);
    drain("R4");
    finish_seq();

    // R6: zero outgoing bytes, start right after flags
    start_pkt(9, 5, 32'h0, 0);
    drain("R6");
    finish_seq();

    // R5: long write over two continuation packets, excess dropped
    start_pkt(9, 100, WR | 32'h0000_000D, 56);
    cont_pkt(40, 0, WR | 32'h0000_000D);
    cont_pkt(20, 0, WR | 32'h0000_000D);
    drain("R5");
    finish_seq();

    // R7: counts over the limit
    start_pkt(9, 257, WR | 32'h1, 4);
    start_pkt(9, 300, 32'h1, 1);
    drain("R7");
    check(busy == 0, "R7", "busy after count error", int'(busy), 0);

    // R8 and R11: disabled wins over bad count
    enable = 1'b0;
    start_pkt(9, 2, WR, 2);
    start_pkt(9, 999, WR | 32'h20, 0);
    drain("R8");
    enable = 1'b1;

    // R9: mode, double-rate and dummy cycles rejected
    start_pkt(9, 1, 32'h0000_0021, 1);
    start_pkt(9, 1, 32'h0000_0201, 1);
    start_pkt(9, 1, 32'h0000_2001, 1);
    // R11: count error wins over mode error
    start_pkt(9, 400, 32'h0000_0041, 1);
    drain("R9");
    multilane_ok = 1'b1;
    start_pkt(9, 8, 32'h0000_0141, 1); // R9 accepted with support
    drain("R9");
    finish_seq();
    multilane_ok = 1'b0;

    // R10: start packet ignored while busy
    start_pkt(9, 0, 32'h1, 1);
    drain("R10");
    start_pkt(9, 2, WR | 32'h1, 3);
    drain("R10");
    check(busy == 1, "R10", "busy held", int'(busy), 1);
    finish_seq();

    // R2: wrong id and swapped byte order ignored
    start_pkt(3, 2, WR | 32'h1, 3);
    start_pkt(16'h0900, 2, WR | 32'h1, 3);
    drain("R2");

    // R12: continuation with nothing collecting
    cont_pkt(5, 0, 0);
    drain("R12");

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule